// File: doc/BRIEF.md
# Speculative-Wakeup Issue Queue

This block is the scheduling window between register rename and the functional units of an out-of-order core. Rename writes up to four instructions per cycle into free slots. Each instruction carries a destination tag, two source tags with ready flags, a load flag and a sequence number that gives its age.

An instruction leaves the window once both of its sources are known to be ready in time. Each cycle the block grants up to four ready instructions, oldest first, and presents them on an issue port that is ordered by age. Wakeup is timed from the latency each producer is expected to have, not from its writeback:

- A granted ALU instruction puts its destination tag on the wakeup bus in its own grant cycle, so a dependent can issue in the very next cycle.
- A granted load puts its tag on the bus one cycle later, so its dependents lose one cycle.

A flush input carries the age of a mispredicted branch and discards every instruction younger than that branch.

Top module: `spec_issue_queue`

## Requirements
- R1: After synchronous reset the window is empty: `iss_valid` is 0 and `full` is 0.
- R2: An instruction dispatched with both sources flagged ready appears on the issue port in the cycle after its dispatch edge.
- R3: A dependent of a non-load producer issues in the cycle immediately after the producer issues, with no empty cycle between them.
- R4: A dependent of a load (`disp_load`=1) cannot issue in the cycle after the load. It issues two cycles after the load.
- R5: At most ISS_W (4) instructions issue per cycle. When more are ready, the oldest are chosen. Slot 0 carries the oldest and later slots carry younger ones. Age compares sequence numbers modulo 2^8: a is older than b when bit 7 of (a-b) is 1, so 254 is older than 0.
- R6: An instruction with a source that is not ready is never issued.
- R7: A source whose tag is on the wakeup bus in the same cycle the instruction is dispatched is recorded as ready. The dependent then issues in the following cycle.
- R8: While `flush_valid` is 1, these rules apply:
  - Every held instruction whose sequence number is strictly younger than `flush_seq` is removed and is not issued in that cycle.
  - Instructions that are older than, or equal to, `flush_seq` are kept.
  - Dispatch is ignored in that cycle.
- R9: `full` is 1 exactly when fewer than DISP_W (4) slots are free. With 16 slots this means 13 or more are held.
- R10: An issued instruction leaves the window and is never issued twice.
- R11: Valid issue slots are packed from slot 0 upward, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | DISP_W | Per-lane dispatch request |
| disp_dst | input | DISP_W x 6 | Destination physical tag |
| disp_src0 | input | DISP_W x 6 | First source tag |
| disp_src0_rdy | input | DISP_W | First source already available |
| disp_src1 | input | DISP_W x 6 | Second source tag |
| disp_src1_rdy | input | DISP_W | Second source already available |
| disp_load | input | DISP_W | Instruction is a load (longer wakeup) |
| disp_seq | input | DISP_W x 8 | Age sequence number |
| full | output | 1 | Fewer than DISP_W free slots; rename must stall |
| iss_valid | output | ISS_W | Issue slot occupied |
| iss_dst | output | ISS_W x 6 | Destination tag of issued instruction |
| iss_load | output | ISS_W | Issued instruction is a load |
| iss_seq | output | ISS_W x 8 | Sequence number of issued instruction |
| flush_valid | input | 1 | Branch mispredict recovery |
| flush_seq | input | 8 | Sequence number of the mispredicted branch |

## Verification
The checks assume these things about the inputs:
- Rename never dispatches while `full` is high.
- The sequence numbers of the instructions held at one time are distinct and span less than half of the 8-bit range.
- Only one instruction in flight writes a given tag at a time.

The directed scenarios start each one from an empty window. Every scenario uses its own fresh tags and consecutive sequence numbers. The capacity scenario stops dispatching as soon as `full` rises and then empties the window with a flush.

// File: rtl/siq_pkg.sv
package siq_pkg;

    localparam int unsigned TAG_W = 6;
    localparam int unsigned SEQ_W = 8;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic vld;
        tag_t dst;
        tag_t src0;
        logic rdy0;
        tag_t src1;
        logic rdy1;
        logic is_ld;
        seq_t seq;
    } iq_ent_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } wake_t;

    // a is older than b in a wrapping sequence space
    function automatic logic seq_older(input seq_t a, input seq_t b);
        seq_t diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

endpackage

// File: rtl/siq_alloc.sv
module siq_alloc #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DISP_W = 4,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]             vld,
    output logic [DISP_W-1:0][IDX_W-1:0] slot,
    output logic [DISP_W-1:0]            slot_ok,
    output logic                         full
);

    logic [CNT_W-1:0] free_cnt;

    // the k-th free slot (lowest index first) goes to dispatch lane k
    always_comb begin
        free_cnt = '0;
        slot     = '0;
        slot_ok  = '0;
        for (int unsigned i = 0; i < DEPTH; i++) begin
            if (!vld[i]) begin
                for (int unsigned k = 0; k < DISP_W; k++) begin
                    if (free_cnt == CNT_W'(k)) begin
                        slot[k]    = IDX_W'(i);
                        slot_ok[k] = 1'b1;
                    end
                end
                free_cnt = free_cnt + 1'b1;
            end
        end
    end

    assign full = (free_cnt < CNT_W'(DISP_W));

endmodule

// File: rtl/siq_select.sv
module siq_select import siq_pkg::*; #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned ISS_W = 4,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned RK_W  = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]            req,
    input  seq_t [DEPTH-1:0]            seq_v,
    output logic [DEPTH-1:0]            gnt,
    output logic [ISS_W-1:0][IDX_W-1:0] pick,
    output logic [ISS_W-1:0]            pick_vld
);

    logic [DEPTH-1:0][RK_W-1:0] rank;

    // rank = number of requesting entries older than this one
    always_comb begin
        for (int unsigned i = 0; i < DEPTH; i++) begin
            rank[i] = '0;
            for (int unsigned j = 0; j < DEPTH; j++) begin
                if (j != i && req[j] && seq_older(seq_v[j], seq_v[i]))
                    rank[i] = rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        gnt      = '0;
        pick     = '0;
        pick_vld = '0;
        for (int unsigned i = 0; i < DEPTH; i++) begin
            if (req[i] && rank[i] < RK_W'(ISS_W)) begin
                gnt[i] = 1'b1;
                for (int unsigned s = 0; s < ISS_W; s++) begin
                    if (rank[i] == RK_W'(s)) begin
                        pick[s]     = IDX_W'(i);
                        pick_vld[s] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/siq_wake.sv
module siq_wake import siq_pkg::*; #(
    parameter int unsigned ISS_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ISS_W-1:0]      iss_vld,
    input  tag_t [ISS_W-1:0]      iss_dst,
    input  logic [ISS_W-1:0]      iss_ld,
    output wake_t [2*ISS_W-1:0]   bc
);

    wake_t [ISS_W-1:0] ld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q <= '0;
        end else begin
            for (int unsigned w = 0; w < ISS_W; w++) begin
                ld_q[w].vld <= iss_vld[w] & iss_ld[w];
                ld_q[w].tag <= iss_dst[w];
            end
        end
    end

    // lanes [ISS_W-1:0]: single-cycle producers, this cycle
    // lanes [2*ISS_W-1:ISS_W]: loads granted one cycle ago
    for (genvar w = 0; w < ISS_W; w++) begin : g_lane
        assign bc[w].vld       = iss_vld[w] & ~iss_ld[w];
        assign bc[w].tag       = iss_dst[w];
        assign bc[ISS_W+w]     = ld_q[w];
    end

endmodule

// File: rtl/spec_issue_queue.sv
module spec_issue_queue import siq_pkg::*; #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DISP_W = 4,
    parameter int unsigned ISS_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DISP_W-1:0]             disp_valid,
    input  logic [DISP_W-1:0][TAG_W-1:0]  disp_dst,
    input  logic [DISP_W-1:0][TAG_W-1:0]  disp_src0,
    input  logic [DISP_W-1:0]             disp_src0_rdy,
    input  logic [DISP_W-1:0][TAG_W-1:0]  disp_src1,
    input  logic [DISP_W-1:0]             disp_src1_rdy,
    input  logic [DISP_W-1:0]             disp_load,
    input  logic [DISP_W-1:0][SEQ_W-1:0]  disp_seq,
    output logic                          full,
    output logic [ISS_W-1:0]              iss_valid,
    output logic [ISS_W-1:0][TAG_W-1:0]   iss_dst,
    output logic [ISS_W-1:0]              iss_load,
    output logic [ISS_W-1:0][SEQ_W-1:0]   iss_seq,
    input  logic                          flush_valid,
    input  logic [SEQ_W-1:0]              flush_seq
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned NB    = 2 * ISS_W;

    iq_ent_t [DEPTH-1:0]             ent_q;
    iq_ent_t [DEPTH-1:0]             ent_d;
    logic    [DEPTH-1:0]             vld_vec;
    logic    [DEPTH-1:0]             both_rdy_vec;
    logic    [DEPTH-1:0]             squash_vec;
    logic    [DEPTH-1:0]             req_vec;
    logic    [DEPTH-1:0]             gnt_vec;
    seq_t    [DEPTH-1:0]             seq_vec;
    logic    [DISP_W-1:0][IDX_W-1:0] slot;
    logic    [DISP_W-1:0]            slot_ok;
    logic    [ISS_W-1:0][IDX_W-1:0]  pick;
    logic    [ISS_W-1:0]             pick_vld;
    wake_t   [NB-1:0]                bc;

    function automatic logic tag_hit(input tag_t t, input wake_t [NB-1:0] b);
        logic h;
        h = 1'b0;
        for (int unsigned n = 0; n < NB; n++)
            h = h | (b[n].vld && b[n].tag == t);
        return h;
    endfunction

    // per-entry status vectors
    always_comb begin
        for (int unsigned i = 0; i < DEPTH; i++) begin
            vld_vec[i]      = ent_q[i].vld;
            both_rdy_vec[i] = ent_q[i].rdy0 & ent_q[i].rdy1;
            seq_vec[i]      = ent_q[i].seq;
            squash_vec[i]   = flush_valid & seq_older(flush_seq, ent_q[i].seq);
        end
    end

    assign req_vec = vld_vec & both_rdy_vec & ~squash_vec;

    siq_alloc #(
        .DEPTH  (DEPTH),
        .DISP_W (DISP_W)
    ) alloc_i (
        .vld     (vld_vec),
        .slot    (slot),
        .slot_ok (slot_ok),
        .full    (full)
    );

    siq_select #(
        .DEPTH (DEPTH),
        .ISS_W (ISS_W)
    ) select_i (
        .req      (req_vec),
        .seq_v    (seq_vec),
        .gnt      (gnt_vec),
        .pick     (pick),
        .pick_vld (pick_vld)
    );

    siq_wake #(
        .ISS_W (ISS_W)
    ) wake_i (
        .clk     (clk),
        .rst     (rst),
        .iss_vld (iss_valid),
        .iss_dst (iss_dst),
        .iss_ld  (iss_load),
        .bc      (bc)
    );

    // issue port, age ordered from slot 0
    always_comb begin
        for (int unsigned s = 0; s < ISS_W; s++) begin
            iss_valid[s] = pick_vld[s];
            iss_dst[s]   = ent_q[pick[s]].dst;
            iss_load[s]  = ent_q[pick[s]].is_ld;
            iss_seq[s]   = ent_q[pick[s]].seq;
        end
    end

    // next state: retire granted, squash younger, wake sources, then dispatch
    always_comb begin
        ent_d = ent_q;
        for (int unsigned i = 0; i < DEPTH; i++) begin
            if (gnt_vec[i] || squash_vec[i]) begin
                ent_d[i].vld = 1'b0;
            end else if (ent_q[i].vld) begin
                ent_d[i].rdy0 = ent_q[i].rdy0 | tag_hit(ent_q[i].src0, bc);
                ent_d[i].rdy1 = ent_q[i].rdy1 | tag_hit(ent_q[i].src1, bc);
            end
        end
        if (!flush_valid) begin
            for (int unsigned k = 0; k < DISP_W; k++) begin
                if (disp_valid[k] && slot_ok[k]) begin
                    ent_d[slot[k]].vld   = 1'b1;
                    ent_d[slot[k]].dst   = disp_dst[k];
                    ent_d[slot[k]].src0  = disp_src0[k];
                    ent_d[slot[k]].rdy0  = disp_src0_rdy[k] | tag_hit(disp_src0[k], bc);
                    ent_d[slot[k]].src1  = disp_src1[k];
                    ent_d[slot[k]].rdy1  = disp_src1_rdy[k] | tag_hit(disp_src1[k], bc);
                    ent_d[slot[k]].is_ld = disp_load[k];
                    ent_d[slot[k]].seq   = disp_seq[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/siq_checker.sv
module siq_checker import siq_pkg::*; #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DISP_W = 4,
    parameter int unsigned ISS_W  = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        full,
    input logic [ISS_W-1:0]            iss_valid,
    input logic [ISS_W-1:0][SEQ_W-1:0] iss_seq,
    input logic                        flush_valid,
    input logic [SEQ_W-1:0]            flush_seq,
    input logic [DEPTH-1:0]            vld_vec,
    input logic [DEPTH-1:0]            both_rdy_vec,
    input logic [DEPTH-1:0]            gnt_vec
);

    for (genvar k = 0; k + 1 < ISS_W; k++) begin : g_slot
        p_slot_contig_r11: assert property (@(posedge clk) disable iff (rst)
            iss_valid[k+1] |-> iss_valid[k]);
        p_slot_order_r5: assert property (@(posedge clk) disable iff (rst)
            (iss_valid[k] && iss_valid[k+1]) |-> seq_older(iss_seq[k], iss_seq[k+1]));
    end

    for (genvar k = 0; k < ISS_W; k++) begin : g_flush
        p_flush_keep_old_r8: assert property (@(posedge clk) disable iff (rst)
            (flush_valid && iss_valid[k]) |-> !seq_older(flush_seq, iss_seq[k]));
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        p_grant_ready_r6: assert property (@(posedge clk) disable iff (rst)
            gnt_vec[i] |-> (vld_vec[i] && both_rdy_vec[i]));
        p_grant_leaves_r10: assert property (@(posedge clk) disable iff (rst)
            gnt_vec[i] |=> !vld_vec[i]);
    end

    p_issue_cap_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt_vec) <= ISS_W);

    p_full_high_r9: assert property (@(posedge clk) disable iff (rst)
        full |-> ($countones(vld_vec) > DEPTH - DISP_W));

    p_full_low_r9: assert property (@(posedge clk) disable iff (rst)
        !full |-> ($countones(vld_vec) <= DEPTH - DISP_W));

endmodule

bind spec_issue_queue siq_checker #(
    .DEPTH  (DEPTH),
    .DISP_W (DISP_W),
    .ISS_W  (ISS_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .full         (full),
    .iss_valid    (iss_valid),
    .iss_seq      (iss_seq),
    .flush_valid  (flush_valid),
    .flush_seq    (flush_seq),
    .vld_vec      (vld_vec),
    .both_rdy_vec (both_rdy_vec),
    .gnt_vec      (gnt_vec)
);

// File: tb/spec_issue_queue_tb.sv
module spec_issue_queue_tb_top;

    logic             clk = 1'b0;
    logic             rst;
    logic [3:0]       disp_valid;
    logic [3:0][5:0]  disp_dst;
    logic [3:0][5:0]  disp_src0;
    logic [3:0]       disp_src0_rdy;
    logic [3:0][5:0]  disp_src1;
    logic [3:0]       disp_src1_rdy;
    logic [3:0]       disp_load;
    logic [3:0][7:0]  disp_seq;
    logic             full;
    logic [3:0]       iss_valid;
    logic [3:0][5:0]  iss_dst;
    logic [3:0]       iss_load;
    logic [3:0][7:0]  iss_seq;
    logic             flush_valid;
    logic [7:0]       flush_seq;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spec_issue_queue dut_i (
        .clk           (clk),
        .rst           (rst),
        .disp_valid    (disp_valid),
        .disp_dst      (disp_dst),
        .disp_src0     (disp_src0),
        .disp_src0_rdy (disp_src0_rdy),
        .disp_src1     (disp_src1),
        .disp_src1_rdy (disp_src1_rdy),
        .disp_load     (disp_load),
        .disp_seq      (disp_seq),
        .full          (full),
        .iss_valid     (iss_valid),
        .iss_dst       (iss_dst),
        .iss_load      (iss_load),
        .iss_seq       (iss_seq),
        .flush_valid   (flush_valid),
        .flush_seq     (flush_seq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        disp_valid    = '0;
        disp_dst      = '0;
        disp_src0     = '0;
        disp_src0_rdy = '0;
        disp_src1     = '0;
        disp_src1_rdy = '0;
        disp_load     = '0;
        disp_seq      = '0;
        flush_valid   = 1'b0;
        flush_seq     = '0;
    endtask

    // next cycle: clear inputs at the falling edge, sample shortly after
    task automatic step();
        @(negedge clk);
        clear_in();
        #1;
    endtask

    task automatic put(input int k, input logic [5:0] dst, input logic [5:0] s0,
                       input bit r0, input logic [5:0] s1, input bit r1,
                       input bit ld, input logic [7:0] sq);
        disp_valid[k]    = 1'b1;
        disp_dst[k]      = dst;
        disp_src0[k]     = s0;
        disp_src0_rdy[k] = r0;
        disp_src1[k]     = s1;
        disp_src1_rdy[k] = r1;
        disp_load[k]     = ld;
        disp_seq[k]      = sq;
    endtask

    task automatic exp_issue(input string req, input logic [3:0] vmask,
                             input logic [3:0][7:0] sq);
        chk(iss_valid == vmask, req, "iss_valid", 32'(iss_valid), 32'(vmask));
        for (int k = 0; k < 4; k++) begin
            if (vmask[k])
                chk(iss_seq[k] == sq[k], req, $sformatf("iss_seq[%0d]", k),
                    32'(iss_seq[k]), 32'(sq[k]));
        end
    endtask

    task automatic t_reset();
        chk(iss_valid == 4'b0, "R1", "iss_valid", 32'(iss_valid), 0);
        chk(full == 1'b0, "R1", "full", 32'(full), 0);
    endtask

    task automatic t_ready_at_dispatch();
        step();
        put(0, 6'd5, 6'd1, 1, 6'd2, 1, 0, 8'd1);
        step();
        exp_issue("R2", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd1});
        chk(iss_dst[0] == 6'd5, "R2", "iss_dst[0]", 32'(iss_dst[0]), 5);
        step();
        exp_issue("R10", 4'b0000, '0);
    endtask

    task automatic t_alu_wake();
        step();
        put(0, 6'd10, 6'd1, 1, 6'd2, 1, 0, 8'd2);
        put(1, 6'd11, 6'd10, 0, 6'd2, 1, 0, 8'd3);
        step();
        exp_issue("R6", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd2});
        step();
        exp_issue("R3", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd3});
        step();
        exp_issue("R10", 4'b0000, '0);
    endtask

    task automatic t_load_wake();
        step();
        put(0, 6'd12, 6'd1, 1, 6'd2, 1, 1, 8'd4);
        put(1, 6'd13, 6'd12, 0, 6'd2, 1, 0, 8'd5);
        step();
        exp_issue("R4", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd4});
        chk(iss_load[0] == 1'b1, "R4", "iss_load[0]", 32'(iss_load[0]), 1);
        step();
        exp_issue("R4", 4'b0000, '0);
        step();
        exp_issue("R4", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd5});
        step();
    endtask

    task automatic t_capture();
        step();
        put(0, 6'd14, 6'd1, 1, 6'd2, 1, 0, 8'd6);
        step();
        exp_issue("R7", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd6});
        put(0, 6'd15, 6'd14, 0, 6'd2, 1, 0, 8'd7);
        step();
        exp_issue("R7", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd7});
        // load variant: dispatch in the cycle of the delayed broadcast
        put(0, 6'd16, 6'd1, 1, 6'd2, 1, 1, 8'd8);
        step();
        exp_issue("R7", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd8});
        step();
        put(0, 6'd17, 6'd2, 1, 6'd16, 0, 0, 8'd9);
        step();
        exp_issue("R7", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd9});
        step();
        exp_issue("R10", 4'b0000, '0);
    endtask

    task automatic t_oldest_first();
        step();
        put(0, 6'd20, 6'd1, 1, 6'd2, 1, 0, 8'd10);
        put(1, 6'd21, 6'd20, 0, 6'd2, 1, 0, 8'd25);
        put(2, 6'd22, 6'd20, 0, 6'd2, 1, 0, 8'd21);
        put(3, 6'd23, 6'd20, 0, 6'd2, 1, 0, 8'd23);
        step();
        exp_issue("R5", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd10});
        put(0, 6'd24, 6'd20, 0, 6'd2, 1, 0, 8'd22);
        put(1, 6'd25, 6'd20, 0, 6'd2, 1, 0, 8'd24);
        put(2, 6'd26, 6'd20, 0, 6'd2, 1, 0, 8'd20);
        step();
        exp_issue("R5", 4'b1111, {8'd23, 8'd22, 8'd21, 8'd20});
        step();
        exp_issue("R11", 4'b0011, {8'd0, 8'd0, 8'd25, 8'd24});
        step();
        // wrap of the sequence space
        put(0, 6'd27, 6'd1, 1, 6'd2, 1, 0, 8'd0);
        put(1, 6'd28, 6'd1, 1, 6'd2, 1, 0, 8'd255);
        put(2, 6'd29, 6'd1, 1, 6'd2, 1, 0, 8'd1);
        put(3, 6'd30, 6'd1, 1, 6'd2, 1, 0, 8'd254);
        step();
        exp_issue("R5", 4'b1111, {8'd1, 8'd0, 8'd255, 8'd254});
        step();
    endtask

    task automatic t_flush();
        step();
        put(0, 6'd31, 6'd1, 1, 6'd2, 1, 0, 8'd40);
        put(1, 6'd32, 6'd1, 1, 6'd2, 1, 0, 8'd41);
        put(2, 6'd33, 6'd1, 1, 6'd2, 1, 0, 8'd42);
        @(negedge clk);
        clear_in();
        flush_valid = 1'b1;
        flush_seq   = 8'd41;
        put(0, 6'd34, 6'd1, 1, 6'd2, 1, 0, 8'd43);
        #1;
        exp_issue("R8", 4'b0011, {8'd0, 8'd0, 8'd41, 8'd40});
        step();
        exp_issue("R8", 4'b0000, '0);
    endtask

    task automatic t_full();
        for (int c = 0; c < 3; c++) begin
            step();
            for (int k = 0; k < 4; k++)
                put(k, 6'(k + 4 * c), 6'd60, 0, 6'd2, 1, 0, 8'(200 + 4 * c + k));
        end
        step();
        chk(full == 1'b0, "R9", "full at 12 held", 32'(full), 0);
        exp_issue("R6", 4'b0000, '0);
        put(0, 6'd12, 6'd60, 0, 6'd2, 1, 0, 8'd212);
        step();
        chk(full == 1'b1, "R9", "full at 13 held", 32'(full), 1);
        flush_valid = 1'b1;
        flush_seq   = 8'd199;
        step();
        chk(full == 1'b0, "R8", "full after flush", 32'(full), 0);
        put(0, 6'd60, 6'd1, 1, 6'd2, 1, 0, 8'd213);
        step();
        exp_issue("R8", 4'b0001, {8'd0, 8'd0, 8'd0, 8'd213});
        step();
        exp_issue("R8", 4'b0000, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        clear_in();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_ready_at_dispatch();
        t_alu_wake();
        t_load_wake();
        t_capture();
        t_oldest_first();
        t_flush();
        t_full();
        step();
        finish_run();
    end

endmodule